// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short supply of instruction bytes ready for a decoder. It owns a single memory bus port and starts its own one-byte fetch cycles whenever a slot is free, so fetching overlaps with execution. Bytes come out of a small first-in first-out store through a pop port. Fetch addresses advance by one for each byte that is kept.

The execution side shares the same bus through an operand-access port. An operand request never interrupts a fetch already on the bus. It is served as soon as that fetch ends, and it wins over any new fetch that would otherwise start. A taken branch or call drives the flush port with a target address. The queue is then emptied, any fetch still on the bus has its data thrown away, and refilling starts at the target.

Bus cycles use a level request. Address, direction and write data are held steady until a one-cycle acknowledge, which also carries read data. The bus never has more than one cycle in flight.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds up to DEPTH (default 6) bytes. They are presented on `pop_data` in the order they were fetched, and the byte fetched from address a is the `bus_rdata` returned for a.
- R2: No fetch cycle starts while the queue holds DEPTH bytes. Once a slot frees up and the bus is idle with no operand request, exactly one new fetch starts, at the next sequential address.
- R3: If an operand request arrives while a fetch is on the bus, the fetch runs to its acknowledge with its address unchanged. The operand cycle is the next bus cycle, and `opr_done` pulses with `opr_rdata` equal to the data read.
- R4: When the bus is idle and the queue has room, a pending operand request starts before any fetch. Its address, write flag and write data appear on the bus one cycle later.
- R5: A one-cycle `flush` empties the queue, so `pop_valid` is low the following cycle. The next fetch uses `flush_addr`, and the fetch address then increments by one per byte kept.
- R6: A fetch that is on the bus when `flush` is asserted completes on the bus, but its returned byte is discarded and never popped.
- R7: While the queue is empty, `pop_valid` is low and `pop_req` has no effect: the next byte popped after a refill is the first byte fetched from the new address.
- R8: A push and a pop in the same cycle lose and duplicate no byte, so a stream popped every cycle that data is valid stays in address order.
- R9: During reset `bus_req` and `pop_valid` are low. The first fetch after reset uses address RESET_ADDR.
- R10: While `bus_req` is high and `bus_ack` low, `bus_addr`, `bus_we` and `bus_wdata` stay constant and `bus_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 8 | Write data for operand writes |
| bus_ack | input | 1 | One-cycle end of the bus cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| pop_req | input | 1 | Consumer takes the head byte |
| pop_valid | output | 1 | Head byte available |
| pop_data | output | 8 | Head byte |
| opr_req | input | 1 | Operand access request, held until `opr_done` |
| opr_we | input | 1 | Operand access is a write |
| opr_addr | input | ADDR_W | Operand address |
| opr_wdata | input | 8 | Operand write data |
| opr_done | output | 1 | Operand access finished |
| opr_rdata | output | 8 | Operand read data, valid with `opr_done` |
| flush | input | 1 | Discard queue and redirect fetching |
| flush_addr | input | ADDR_W | New fetch address |

## Verification
The bench uses a slave that can hold back the acknowledge for one chosen address. This lets it park a fetch on the bus and then apply a flush or an operand request. A design that enqueued the stale byte would pop it ahead of the target. A design that aborted or reordered the fetch would show a changed bus address or serve the operand first.

Other tests aim at the full boundary and at an empty pop. A queue off by one at full starts a seventh fetch. A pop that leaks through on empty skips or duplicates the first refilled byte.

A stream that pops in every cycle that data is valid forces pushes and pops into the same cycle. A wrong count or pointer update there shows up as a byte out of sequence.

// File: rtl/pq_pkg.sv
// Shared types for the prefetch queue.
// Assumes: nothing beyond the standard language.
package pq_pkg;

    // Owner of the single bus port
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_FETCH = 2'd1,
        ARB_OPER  = 2'd2
    } arb_state_t;

endpackage

// File: rtl/pq_fifo.sv
// Byte store of the prefetch queue: DEPTH slots in circular order.
// Assumes: push is only asserted when a slot is free (the bus side
// starts a fetch only with room, and pops only ever add room).
// A clear empties the store and wins over push and pop in that cycle.
module pq_fifo #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        push,
    input  logic [DATA_W-1:0]           push_data,
    input  logic                        pop_req,
    output logic                        pop_valid,
    output logic [DATA_W-1:0]           pop_data,
    output logic                        room,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign pop_valid = (count_q != '0) && !clear;
    assign do_pop    = pop_req && pop_valid;
    assign pop_data  = slot_q[rd_ptr_q];
    assign room      = (count_q < CNT_W'(DEPTH));
    assign count     = count_q;

    // One storage register per slot, written when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !clear && (wr_ptr_q == PTR_W'(i))) begin
                slot_q[i] <= push_data;
            end
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push)   wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop) rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({push, do_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/pq_fetch_addr.sv
// Sequential fetch pointer: reloads on redirect, steps by one per kept byte.
// Assumes: load and inc may coincide; load wins.
module pq_fetch_addr #(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    assign addr = addr_q;

    // Address register update
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= RESET_ADDR;
        else if (load) addr_q <= load_addr;
        else if (inc)  addr_q <= addr_q + ADDR_W'(1);
    end

endmodule

// File: rtl/pq_arbiter.sv
// Bus owner selection and bus cycle registers.
// Starts at most one cycle at a time, only from idle. Operand requests beat
// fetch starts; a running fetch is never cut short. A flush marks a running
// fetch so that its returned byte is dropped, and holds off a start in the
// flush cycle so the next fetch picks up the reloaded address.
// Assumes: opr_req is held until opr_done; bus_ack lasts one cycle.
module pq_arbiter
    import pq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              room,
    input  logic              flush,
    input  logic              opr_req,
    input  logic              opr_we,
    input  logic [ADDR_W-1:0] opr_addr,
    input  logic [DATA_W-1:0] opr_wdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              fetch_busy,
    output logic              push,
    output logic              opr_done
);
    arb_state_t        state_q, state_d;
    logic              start_fetch, start_opr;
    logic              drop_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Next owner: operand first, fetch only with room, nothing during flush
    always_comb begin
        state_d     = state_q;
        start_fetch = 1'b0;
        start_opr   = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (!flush) begin
                    if (opr_req) begin
                        state_d   = ARB_OPER;
                        start_opr = 1'b1;
                    end else if (room) begin
                        state_d     = ARB_FETCH;
                        start_fetch = 1'b1;
                    end
                end
            end
            ARB_FETCH, ARB_OPER: begin
                if (bus_ack) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // Owner register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Bus cycle attributes, captured at cycle start and held to the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start_opr) begin
            addr_q  <= opr_addr;
            we_q    <= opr_we;
            wdata_q <= opr_wdata;
        end else if (start_fetch) begin
            addr_q  <= fetch_addr;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end
    end

    // Drop mark for a fetch overtaken by a flush
    always_ff @(posedge clk) begin
        if (!rst_n || start_fetch) begin
            drop_q <= 1'b0;
        end else if (state_q == ARB_FETCH) begin
            if (bus_ack)    drop_q <= 1'b0;
            else if (flush) drop_q <= 1'b1;
        end
    end

    assign bus_req    = (state_q != ARB_IDLE);
    assign bus_we     = we_q;
    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign fetch_busy = (state_q == ARB_FETCH);
    assign push       = fetch_busy && bus_ack && !drop_q && !flush;
    assign opr_done   = (state_q == ARB_OPER) && bus_ack;

endmodule

// File: rtl/prefetch_queue.sv
// Instruction prefetch byte queue: fetch pointer, bus arbiter and byte store.
// Assumes: a single-outstanding bus with level request and one-cycle
// acknowledge that also carries read data.
module prefetch_queue #(
    parameter int                ADDR_W     = 20,
    parameter int                DEPTH      = 6,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [7:0]        pop_data,
    input  logic              opr_req,
    input  logic              opr_we,
    input  logic [ADDR_W-1:0] opr_addr,
    input  logic [7:0]        opr_wdata,
    output logic              opr_done,
    output logic [7:0]        opr_rdata,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr
);
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              room;
    logic              push;
    logic              fetch_busy;
    logic [ADDR_W-1:0] fetch_addr;
    logic [CNT_W-1:0]  fifo_count;

    pq_fetch_addr #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flush),
        .load_addr (flush_addr),
        .inc       (push),
        .addr      (fetch_addr)
    );

    pq_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .room       (room),
        .flush      (flush),
        .opr_req    (opr_req),
        .opr_we     (opr_we),
        .opr_addr   (opr_addr),
        .opr_wdata  (opr_wdata),
        .fetch_addr (fetch_addr),
        .bus_ack    (bus_ack),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .fetch_busy (fetch_busy),
        .push       (push),
        .opr_done   (opr_done)
    );

    pq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (push),
        .push_data (bus_rdata),
        .pop_req   (pop_req),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .room      (room),
        .count     (fifo_count)
    );

    assign opr_rdata = bus_rdata;

endmodule

// File: rtl/pq_checker.sv
// Temporal checks for the prefetch queue, attached by bind below.
// Assumes: observes the top's ports plus the store occupancy and fetch owner.
module pq_checker #(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_ack,
    input logic                       pop_valid,
    input logic                       opr_req,
    input logic                       flush,
    input logic                       fetch_busy,
    input logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // R1: occupancy never exceeds the depth
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R2: a fetch only starts when the store had a free slot
    a_r2_no_fetch_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_busy) |-> ($past(cnt) < CNT_W'(DEPTH)));

    // R3: a running fetch is never cut short
    a_r3_fetch_runs_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy && !bus_ack |=> fetch_busy);

    // R4: from idle, a pending operand request starts an operand cycle
    a_r4_operand_first: assert property (@(posedge clk) disable iff (!rst_n)
        opr_req && !bus_req && !flush |=> bus_req && !fetch_busy);

    // R5: flush leaves the store empty
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

    // R7: nothing offered from an empty store
    a_r7_empty_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !pop_valid);

    // R10: bus cycle attributes hold until acknowledge
    a_r10_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

endmodule

bind prefetch_queue pq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_ack    (bus_ack),
    .pop_valid  (pop_valid),
    .opr_req    (opr_req),
    .flush      (flush),
    .fetch_busy (fetch_busy),
    .cnt        (fifo_count)
);

// File: tb/tb_prefetch_queue.sv
// Directed bench for prefetch_queue: one task per scenario.
module tb_prefetch_queue;
    localparam int          ADDR_W     = 20;
    localparam int          DEPTH      = 6;
    localparam logic [19:0] RESET_ADDR = 20'hFFFF0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_ack = 1'b0;
    logic [7:0]        bus_rdata = 8'h00;
    logic              pop_req = 1'b0;
    logic              pop_valid;
    logic [7:0]        pop_data;
    logic              opr_req = 1'b0, opr_we = 1'b0;
    logic [ADDR_W-1:0] opr_addr = '0;
    logic [7:0]        opr_wdata = 8'h00;
    logic              opr_done;
    logic [7:0]        opr_rdata;
    logic              flush = 1'b0;
    logic [ADDR_W-1:0] flush_addr = '0;

    int checks = 0;
    int errors = 0;

    // slave model controls
    int                lat = 1;
    int                scnt = 0;
    logic              hold_en = 1'b0;
    logic [ADDR_W-1:0] hold_addr = '0;

    // bus monitor
    int                starts = 0;
    logic              prev_req = 1'b0;
    logic [ADDR_W-1:0] last_start_addr = '0;

    always #4 clk = ~clk;

    prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .opr_req(opr_req), .opr_we(opr_we), .opr_addr(opr_addr), .opr_wdata(opr_wdata),
        .opr_done(opr_done), .opr_rdata(opr_rdata),
        .flush(flush), .flush_addr(flush_addr)
    );

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Memory slave: acknowledges after lat waiting cycles, can stall one address
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            scnt    <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
            scnt    <= 0;
        end else if (bus_req && !(hold_en && bus_addr == hold_addr)) begin
            if (scnt >= lat) begin
                bus_ack   <= 1'b1;
                bus_rdata <= mem_byte(bus_addr);
            end else begin
                scnt <= scnt + 1;
            end
        end
    end

    // Counts bus cycle starts and remembers the last start address
    always @(posedge clk) begin
        if (bus_req && !prev_req) begin
            starts          = starts + 1;
            last_start_addr = bus_addr;
        end
        prev_req = bus_req;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_expect(input logic [ADDR_W-1:0] a, input string req);
        int n = 0;
        @(negedge clk);
        while (!pop_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(pop_valid, req, "pop_valid before pop", 32'(pop_valid), 32'd1);
        check(pop_data == mem_byte(a), req, "popped byte", 32'(pop_data), 32'(mem_byte(a)));
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic do_flush(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        flush      = 1'b1;
        flush_addr = a;
        @(negedge clk);
        flush      = 1'b0;
    endtask

    task automatic wait_fetch_at(input logic [ADDR_W-1:0] a, input string req);
        int n = 0;
        while (!(bus_req && bus_addr == a) && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(bus_req && bus_addr == a, req, "fetch on bus at address", 32'(bus_addr), 32'(a));
    endtask

    // R9: reset state and first fetch address
    task automatic t_reset;
        int n = 0;
        rst_n = 1'b0;
        wait_neg(3);
        check(!bus_req, "R9", "bus_req in reset", 32'(bus_req), 32'd0);
        check(!pop_valid, "R9", "pop_valid in reset", 32'(pop_valid), 32'd0);
        rst_n = 1'b1;
        while (!bus_req && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(bus_req && bus_addr == RESET_ADDR, "R9", "first fetch address",
              32'(bus_addr), 32'(RESET_ADDR));
    endtask

    // R1, R2: fills to the depth only, then bytes come out in address order
    task automatic t_fill;
        wait_neg(60);
        check(starts == DEPTH, "R2", "fetch starts with no pops", 32'(starts), 32'(DEPTH));
        check(!bus_req, "R2", "bus idle when full", 32'(bus_req), 32'd0);
        for (int i = 0; i < DEPTH; i++) pop_expect(RESET_ADDR + 20'(i), "R1");
    endtask

    // R2: full queue stays idle; one pop makes exactly one fetch at the next address
    task automatic t_full_resume;
        int s0;
        wait_neg(40);
        s0 = starts;
        wait_neg(30);
        check(starts == s0, "R2", "no fetch while full", 32'(starts), 32'(s0));
        pop_expect(RESET_ADDR + 20'd6, "R2");
        wait_neg(20);
        check(starts == s0 + 1, "R2", "single refill fetch", 32'(starts), 32'(s0 + 1));
        check(last_start_addr == RESET_ADDR + 20'd12, "R2", "refill address",
              32'(last_start_addr), 32'(RESET_ADDR + 20'd12));
    endtask

    // R5: flush empties and redirects, addresses step by one
    task automatic t_flush;
        logic [ADDR_W-1:0] t = 20'h12340;
        do_flush(t);
        check(!pop_valid, "R5", "pop_valid after flush", 32'(pop_valid), 32'd0);
        for (int i = 0; i < 8; i++) pop_expect(t + 20'(i), "R5");
    endtask

    // R6, R10: a stalled fetch overtaken by a flush keeps its bus address and is dropped
    task automatic t_drop;
        logic [ADDR_W-1:0] a = 20'h23400;
        logic [ADDR_W-1:0] b = 20'h45670;
        hold_en   = 1'b1;
        hold_addr = a;
        do_flush(a);
        wait_fetch_at(a, "R6");
        do_flush(b);
        wait_neg(3);
        check(bus_req && bus_addr == a, "R10", "stalled address held", 32'(bus_addr), 32'(a));
        check(!pop_valid, "R6", "nothing queued while stalled", 32'(pop_valid), 32'd0);
        hold_en = 1'b0;
        pop_expect(b, "R6");
        pop_expect(b + 20'd1, "R6");
    endtask

    // R3: operand request during a fetch waits for it, then goes next
    task automatic t_oper_during_fetch;
        logic [ADDR_W-1:0] c = 20'h30000;
        logic [ADDR_W-1:0] x = 20'h80010;
        int n = 0;
        hold_en   = 1'b1;
        hold_addr = c;
        do_flush(c);
        wait_fetch_at(c, "R3");
        opr_req  = 1'b1;
        opr_we   = 1'b0;
        opr_addr = x;
        wait_neg(4);
        check(bus_req && bus_addr == c, "R3", "fetch not aborted", 32'(bus_addr), 32'(c));
        check(!opr_done, "R3", "operand not served early", 32'(opr_done), 32'd0);
        hold_en = 1'b0;
        while (!opr_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(opr_done, "R3", "operand done", 32'(opr_done), 32'd1);
        check(bus_addr == x, "R3", "operand address", 32'(bus_addr), 32'(x));
        check(opr_rdata == mem_byte(x), "R3", "operand read data",
              32'(opr_rdata), 32'(mem_byte(x)));
        opr_req = 1'b0;
        pop_expect(c, "R3");
    endtask

    // R4: idle bus with room serves the operand request before the next fetch
    task automatic t_oper_priority;
        logic [ADDR_W-1:0] d = 20'h50000;
        logic [ADDR_W-1:0] y = 20'h80077;
        int n = 0;
        do_flush(d);
        wait_neg(40);
        check(pop_valid && pop_data == mem_byte(d), "R4", "head before pop",
              32'(pop_data), 32'(mem_byte(d)));
        pop_req = 1'b1;
        @(negedge clk);
        pop_req   = 1'b0;
        opr_req   = 1'b1;
        opr_we    = 1'b1;
        opr_addr  = y;
        opr_wdata = 8'h3C;
        @(negedge clk);
        check(bus_req && bus_addr == y, "R4", "operand wins start", 32'(bus_addr), 32'(y));
        check(bus_we && bus_wdata == 8'h3C, "R4", "write attributes",
              {23'd0, bus_we, bus_wdata}, {23'd0, 1'b1, 8'h3C});
        while (!opr_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(opr_done, "R4", "operand write done", 32'(opr_done), 32'd1);
        opr_req = 1'b0;
        opr_we  = 1'b0;
        n = 0;
        @(negedge clk);
        while (!bus_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(bus_req && !bus_we && bus_addr == d + 20'd6, "R4", "following fetch",
              32'(bus_addr), 32'(d + 20'd6));
    endtask

    // R7: popping an empty queue has no effect
    task automatic t_empty_pop;
        logic [ADDR_W-1:0] e = 20'h61200;
        hold_en   = 1'b1;
        hold_addr = e;
        do_flush(e);
        wait_neg(2);
        check(!pop_valid, "R7", "empty before pops", 32'(pop_valid), 32'd0);
        pop_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!pop_valid, "R7", "empty during pops", 32'(pop_valid), 32'd0);
        end
        pop_req = 1'b0;
        hold_en = 1'b0;
        pop_expect(e, "R7");
        pop_expect(e + 20'd1, "R7");
    endtask

    // R8: popping whenever valid makes pushes and pops coincide
    task automatic t_stream;
        logic [ADDR_W-1:0] f = 20'h70FFE;
        int got = 0;
        int n = 0;
        lat = 0;
        do_flush(f);
        wait_neg(8);
        while (got < 20 && n < 600) begin
            @(negedge clk);
            n++;
            if (pop_valid) begin
                check(pop_data == mem_byte(f + 20'(got)), "R8", "streamed byte",
                      32'(pop_data), 32'(mem_byte(f + 20'(got))));
                got++;
                pop_req = 1'b1;
            end else begin
                pop_req = 1'b0;
            end
        end
        @(negedge clk);
        pop_req = 1'b0;
        check(got == 20, "R8", "bytes streamed", 32'(got), 32'd20);
        lat = 1;
    endtask

    initial begin
        t_reset();
        t_fill();
        t_full_resume();
        t_flush();
        t_drop();
        t_oper_during_fetch();
        t_oper_priority();
        t_empty_pop();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule